// File: doc/BRIEF.md
# Per-Lane Banked Stream Staging Memory

This block is the on-chip staging store that sits between a memory or I/O engine and a row of SIMD compute lanes. It holds one bank per lane. A wide memory-side port moves a whole row (one word per lane) per cycle, so stream blocks can be loaded ahead of use or drained back out. Each lane has one write port and two read ports, and every one of them reaches only that lane's own bank. A producer kernel therefore writes its slice of an intermediate stream block, and a consumer kernel later reads that same block in place.

Space is handed out through a small table of stream slots. A controller issues allocate, free and seal commands over a command port. Allocation places a stream as one contiguous run of rows at the same offset in every bank, using a deterministic first-fit search. Storage is given back only when the controller explicitly frees a dead stream; nothing is ever evicted. Lanes that read a stream before it has been sealed as complete are stalled.

Top module: `srf_core`

## Requirements
- R1: Stream element i lives in lane (i mod LANES) at bank row base + floor(i / LANES). Lanes address a stream by the local index floor(i / LANES). Memory-side row r of a stream carries elements r*LANES to r*LANES+LANES-1, with lane l's word in bits [l*WORD_W +: WORD_W].
- R2: cmd_op_i is encoded as 2'b00 none, 2'b01 allocate, 2'b10 free and 2'b11 seal. An allocate reserves ceil(len / LANES) rows. The base is chosen by testing candidates in order: row 0 first, then the end row of each live slot in slot order. The first candidate that fits inside the bank without overlapping a live slot is taken. One cycle after any command, cmd_ack_o pulses, and cmd_base_o shows the chosen base when the allocation succeeds.
- R3: An allocate with length 0, or on a slot that is already live, or that finds no fitting candidate, is refused. The refusal raises cmd_err_o with cmd_ack_o and leaves the slot table and all stored data unchanged.
- R4: Rows are reclaimed only by a free command. A free or seal on a slot that is not live is refused with cmd_err_o. Freeing a slot does not erase its rows.
- R5: A lane read that hits a live stream which is not yet sealed raises that port's lane_rstall_o in the same cycle and produces no lane_rvalid_o in the next cycle. Allocation clears the sealed state, and a seal command sets it.
- R6: An accepted read returns its data with the valid flag exactly one cycle later. Each lane's two read ports work independently in the same cycle. Memory-side reads are not gated by the sealed state.
- R7: A read and a write to the same bank row in one cycle return the old contents. This holds both for lane ports and for the memory-side port.
- R8: While mem_we_i or mem_re_i is high, every lane request stalls. lane_wstall_o and lane_rstall_o are raised, no lane write lands, and no lane read completes.
- R9: A lane access whose index is at or beyond the stream's row count, or whose slot is not live, is dropped. It writes nothing, returns no valid and raises no stall.
- R10: After reset all slots are free and cmd_ack_o, cmd_err_o, lane_rvalid_o and mem_rvalid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code (R2) |
| cmd_id_i | input | ID_W | Target slot |
| cmd_len_i | input | LEN_W | Stream length in elements (allocate) |
| cmd_ack_o | output | 1 | Command completed, one cycle after the strobe |
| cmd_err_o | output | 1 | Command refused |
| cmd_base_o | output | PTR_W | Base row of the last successful allocation |
| mem_we_i | input | 1 | Memory-side row write |
| mem_re_i | input | 1 | Memory-side row read |
| mem_id_i | input | ID_W | Memory-side slot |
| mem_row_i | input | ROW_W | Row within the stream |
| mem_wdata_i | input | LANES*WORD_W | Row write data, lane l at [l*WORD_W +: WORD_W] |
| mem_rdata_o | output | LANES*WORD_W | Row read data |
| mem_rvalid_o | output | 1 | Row read data valid |
| lane_we_i | input | LANES | Per-lane write request |
| lane_wid_i | input | LANES*ID_W | Per-lane write slot |
| lane_widx_i | input | LANES*ROW_W | Per-lane write local index |
| lane_wdata_i | input | LANES*WORD_W | Per-lane write data |
| lane_wstall_o | output | LANES | Per-lane write stalled |
| lane_re_i | input | 2*LANES | Read request, port q = 2*lane + p |
| lane_rid_i | input | 2*LANES*ID_W | Read slot per port |
| lane_ridx_i | input | 2*LANES*ROW_W | Read local index per port |
| lane_rdata_o | output | 2*LANES*WORD_W | Read data per port |
| lane_rvalid_o | output | 2*LANES | Read data valid per port |
| lane_rstall_o | output | 2*LANES | Read stalled per port |

## Verification
The bench replays first-fit placement against its own arithmetic model. It covers refusals for a full bank, zero length and a live slot, and a hole left behind by a free. A wrong candidate order would show up as a misplaced base, and a refusal that still updates the table would appear as overlapping streams in later data reads. Every element of a loaded stream is swept through both read ports of all lanes, so a wrong lane or row mapping returns another element's tag. Stalls are probed on an unsealed stream and under memory-side traffic; a design that ignores either would hand out data or let a lane write land. Write-versus-read collisions must return old data, and an out-of-range write is aimed at the neighbouring stream's first row, where a missing bounds check would corrupt that row.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ALLOC = 2'b01,
    OP_FREE  = 2'b10,
    OP_SEAL  = 2'b11
  } srf_op_e;
endpackage

// File: rtl/srf_desc_table.sv
module srf_desc_table import srf_pkg::*; #(
  parameter int LANES = 8,
  parameter int ROWS  = 64,
  parameter int SLOTS = 4,
  parameter int PTR_W = 7,
  parameter int ID_W  = 2,
  parameter int LEN_W = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  input  logic [1:0]                   cmd_op_i,
  input  logic [ID_W-1:0]              cmd_id_i,
  input  logic [LEN_W-1:0]             cmd_len_i,
  output logic                         cmd_ack_o,
  output logic                         cmd_err_o,
  output logic [PTR_W-1:0]             cmd_base_o,
  output logic [SLOTS-1:0]             slot_vld_o,
  output logic [SLOTS-1:0]             slot_sealed_o,
  output logic [SLOTS-1:0][PTR_W-1:0]  slot_base_o,
  output logic [SLOTS-1:0][PTR_W-1:0]  slot_rows_o
);
  srf_op_e                     op;
  logic [SLOTS-1:0]            vld_q, sealed_q;
  logic [SLOTS-1:0][PTR_W-1:0] base_q, rows_q;
  logic [31:0]                 need;
  logic [SLOTS:0][31:0]        cand;
  logic [SLOTS:0]              cand_ok, fit;
  logic [PTR_W-1:0]            pick;
  logic                        pick_ok, err;
  logic                        ack_q, err_q;
  logic [PTR_W-1:0]            base_out_q;

  assign op   = srf_op_e'(cmd_op_i);
  assign need = (32'(cmd_len_i) + 32'(LANES - 1)) / 32'(LANES);

  // first-fit: row 0, then the end row of each live slot, in slot order
  always_comb begin
    cand[0]    = '0;
    cand_ok[0] = 1'b1;
    for (int k = 0; k < SLOTS; k++) begin
      cand[k+1]    = 32'(base_q[k]) + 32'(rows_q[k]);
      cand_ok[k+1] = vld_q[k];
    end
    for (int c = 0; c <= SLOTS; c++) begin
      fit[c] = cand_ok[c] && (cand[c] + need <= 32'(ROWS));
      for (int k = 0; k < SLOTS; k++)
        if (vld_q[k] && !((cand[c] + need <= 32'(base_q[k])) ||
                          (cand[c] >= 32'(base_q[k]) + 32'(rows_q[k]))))
          fit[c] = 1'b0;
    end
    pick    = '0;
    pick_ok = 1'b0;
    for (int c = SLOTS; c >= 0; c--)
      if (fit[c]) begin
        pick    = cand[c][PTR_W-1:0];
        pick_ok = 1'b1;
      end
  end

  always_comb begin
    case (op)
      OP_ALLOC: err = (cmd_len_i == '0) || vld_q[cmd_id_i] || !pick_ok;
      OP_FREE,
      OP_SEAL:  err = !vld_q[cmd_id_i];
      default:  err = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= '0;
      sealed_q   <= '0;
      base_q     <= '0;
      rows_q     <= '0;
      ack_q      <= 1'b0;
      err_q      <= 1'b0;
      base_out_q <= '0;
    end else begin
      ack_q <= cmd_valid_i;
      err_q <= cmd_valid_i && err;
      if (cmd_valid_i && !err) begin
        case (op)
          OP_ALLOC: begin
            vld_q[cmd_id_i]    <= 1'b1;
            sealed_q[cmd_id_i] <= 1'b0;
            base_q[cmd_id_i]   <= pick;
            rows_q[cmd_id_i]   <= need[PTR_W-1:0];
            base_out_q         <= pick;
          end
          OP_FREE: begin
            vld_q[cmd_id_i]    <= 1'b0;
            sealed_q[cmd_id_i] <= 1'b0;
          end
          OP_SEAL: sealed_q[cmd_id_i] <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign cmd_ack_o     = ack_q;
  assign cmd_err_o     = err_q;
  assign cmd_base_o    = base_out_q;
  assign slot_vld_o    = vld_q;
  assign slot_sealed_o = sealed_q;
  assign slot_base_o   = base_q;
  assign slot_rows_o   = rows_q;

  AST_REFUSE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> (vld_q == $past(vld_q))) else $error("refusal changed table"); // R3

  for (genvar a = 0; a < SLOTS; a++) begin : g_chk
    AST_SLOT_IN_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[a] |-> (32'(base_q[a]) + 32'(rows_q[a]) <= 32'(ROWS))) else $error("slot past bank end"); // R2
    for (genvar b = a + 1; b < SLOTS; b++) begin : g_pair
      AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q[a] && vld_q[b]) |->
          ((32'(base_q[a]) + 32'(rows_q[a]) <= 32'(base_q[b])) ||
           (32'(base_q[b]) + 32'(rows_q[b]) <= 32'(base_q[a])))) else $error("slots overlap"); // R2
    end
  end
endmodule

// File: rtl/srf_xlate.sv
module srf_xlate #(
  parameter int SLOTS = 4,
  parameter int PTR_W = 7,
  parameter int ID_W  = 2,
  parameter int ROW_W = 6
) (
  input  logic [ID_W-1:0]              id_i,
  input  logic [ROW_W-1:0]             idx_i,
  input  logic [SLOTS-1:0]             slot_vld_i,
  input  logic [SLOTS-1:0][PTR_W-1:0]  slot_base_i,
  input  logic [SLOTS-1:0][PTR_W-1:0]  slot_rows_i,
  output logic [ROW_W-1:0]             addr_o,
  output logic                         hit_o
);
  assign addr_o = ROW_W'(slot_base_i[id_i] + PTR_W'(idx_i));
  assign hit_o  = slot_vld_i[id_i] && (PTR_W'(idx_i) < slot_rows_i[id_i]);
endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
  parameter int WORD_W = 32,
  parameter int ROWS   = 64,
  parameter int ROW_W  = 6
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [ROW_W-1:0]            waddr_i,
  input  logic [WORD_W-1:0]           wdata_i,
  input  logic [1:0]                  re_i,
  input  logic [1:0][ROW_W-1:0]       raddr_i,
  output logic [1:0][WORD_W-1:0]      rdata_o
);
  logic [WORD_W-1:0] mem [ROWS];

  // nonblocking read before write: a colliding read sees the old word
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    for (int p = 0; p < 2; p++)
      if (re_i[p]) rdata_o[p] <= mem[raddr_i[p]];
  end
endmodule

// File: rtl/srf_core.sv
module srf_core #(
  parameter int LANES  = 8,
  parameter int WORD_W = 32,
  parameter int ROWS   = 64,
  parameter int SLOTS  = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int PTR_W = ROW_W + 1,
  localparam int ID_W  = $clog2(SLOTS),
  localparam int LEN_W = $clog2(LANES * ROWS) + 1,
  localparam int NRP   = 2 * LANES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  input  logic [1:0]                  cmd_op_i,
  input  logic [ID_W-1:0]             cmd_id_i,
  input  logic [LEN_W-1:0]            cmd_len_i,
  output logic                        cmd_ack_o,
  output logic                        cmd_err_o,
  output logic [PTR_W-1:0]            cmd_base_o,
  input  logic                        mem_we_i,
  input  logic                        mem_re_i,
  input  logic [ID_W-1:0]             mem_id_i,
  input  logic [ROW_W-1:0]            mem_row_i,
  input  logic [LANES*WORD_W-1:0]     mem_wdata_i,
  output logic [LANES*WORD_W-1:0]     mem_rdata_o,
  output logic                        mem_rvalid_o,
  input  logic [LANES-1:0]            lane_we_i,
  input  logic [LANES*ID_W-1:0]       lane_wid_i,
  input  logic [LANES*ROW_W-1:0]      lane_widx_i,
  input  logic [LANES*WORD_W-1:0]     lane_wdata_i,
  output logic [LANES-1:0]            lane_wstall_o,
  input  logic [NRP-1:0]              lane_re_i,
  input  logic [NRP*ID_W-1:0]         lane_rid_i,
  input  logic [NRP*ROW_W-1:0]        lane_ridx_i,
  output logic [NRP*WORD_W-1:0]       lane_rdata_o,
  output logic [NRP-1:0]              lane_rvalid_o,
  output logic [NRP-1:0]              lane_rstall_o
);
  logic [SLOTS-1:0]            slot_vld, slot_sealed;
  logic [SLOTS-1:0][PTR_W-1:0] slot_base, slot_rows;
  logic [ROW_W-1:0]            mem_addr;
  logic                        mem_hit, mem_busy;
  logic [NRP-1:0]              rd_acc, rvalid_q;
  logic                        mem_rvalid_q;

  assign mem_busy = mem_we_i | mem_re_i;

  srf_desc_table #(.LANES(LANES), .ROWS(ROWS), .SLOTS(SLOTS), .PTR_W(PTR_W),
                   .ID_W(ID_W), .LEN_W(LEN_W)) u_tab (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_id_i, .cmd_len_i,
    .cmd_ack_o, .cmd_err_o, .cmd_base_o,
    .slot_vld_o(slot_vld), .slot_sealed_o(slot_sealed),
    .slot_base_o(slot_base), .slot_rows_o(slot_rows)
  );

  srf_xlate #(.SLOTS(SLOTS), .PTR_W(PTR_W), .ID_W(ID_W), .ROW_W(ROW_W)) u_mxl (
    .id_i(mem_id_i), .idx_i(mem_row_i), .slot_vld_i(slot_vld),
    .slot_base_i(slot_base), .slot_rows_i(slot_rows),
    .addr_o(mem_addr), .hit_o(mem_hit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ROW_W-1:0]         w_addr;
    logic                     w_hit, b_we;
    logic [ROW_W-1:0]         b_waddr;
    logic [WORD_W-1:0]        b_wdata;
    logic [ROW_W-1:0]         r_addr [2];
    logic                     r_hit  [2];
    logic [1:0]               b_re;
    logic [1:0][ROW_W-1:0]    b_raddr;
    logic [1:0][WORD_W-1:0]   b_rdata;

    srf_xlate #(.SLOTS(SLOTS), .PTR_W(PTR_W), .ID_W(ID_W), .ROW_W(ROW_W)) u_wxl (
      .id_i(lane_wid_i[l*ID_W +: ID_W]), .idx_i(lane_widx_i[l*ROW_W +: ROW_W]),
      .slot_vld_i(slot_vld), .slot_base_i(slot_base), .slot_rows_i(slot_rows),
      .addr_o(w_addr), .hit_o(w_hit)
    );

    for (genvar p = 0; p < 2; p++) begin : g_rp
      localparam int Q = 2 * l + p;
      logic sealed;
      srf_xlate #(.SLOTS(SLOTS), .PTR_W(PTR_W), .ID_W(ID_W), .ROW_W(ROW_W)) u_rxl (
        .id_i(lane_rid_i[Q*ID_W +: ID_W]), .idx_i(lane_ridx_i[Q*ROW_W +: ROW_W]),
        .slot_vld_i(slot_vld), .slot_base_i(slot_base), .slot_rows_i(slot_rows),
        .addr_o(r_addr[p]), .hit_o(r_hit[p])
      );
      assign sealed           = slot_sealed[lane_rid_i[Q*ID_W +: ID_W]];
      assign rd_acc[Q]        = lane_re_i[Q] && r_hit[p] && sealed && !mem_busy;
      assign lane_rstall_o[Q] = lane_re_i[Q] && (mem_busy || (r_hit[p] && !sealed));
      assign lane_rdata_o[Q*WORD_W +: WORD_W] = b_rdata[p];

      AST_STALL_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lane_rstall_o[Q] |=> !lane_rvalid_o[Q]) else $error("stalled read returned data"); // R5
      AST_MEM_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_busy && lane_re_i[Q]) |=> !lane_rvalid_o[Q]) else $error("lane read beat memory port"); // R8
    end

    // memory side owns write port and read port 0 when active
    always_comb begin
      b_we    = 1'b0;
      b_waddr = w_addr;
      b_wdata = lane_wdata_i[l*WORD_W +: WORD_W];
      if (mem_we_i) begin
        b_we    = mem_hit;
        b_waddr = mem_addr;
        b_wdata = mem_wdata_i[l*WORD_W +: WORD_W];
      end else if (lane_we_i[l] && w_hit && !mem_re_i) begin
        b_we    = 1'b1;
      end
      b_raddr[0] = mem_re_i ? mem_addr : r_addr[0];
      b_raddr[1] = r_addr[1];
      b_re[0]    = (mem_re_i && mem_hit) || rd_acc[2*l];
      b_re[1]    = rd_acc[2*l+1];
    end

    assign lane_wstall_o[l] = lane_we_i[l] && mem_busy;
    assign mem_rdata_o[l*WORD_W +: WORD_W] = b_rdata[0];

    srf_bank #(.WORD_W(WORD_W), .ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk_i, .we_i(b_we), .waddr_i(b_waddr), .wdata_i(b_wdata),
      .re_i(b_re), .raddr_i(b_raddr), .rdata_o(b_rdata)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q     <= '0;
      mem_rvalid_q <= 1'b0;
    end else begin
      rvalid_q     <= rd_acc;
      mem_rvalid_q <= mem_re_i && mem_hit;
    end
  end

  assign lane_rvalid_o = rvalid_q;
  assign mem_rvalid_o  = mem_rvalid_q;

  AST_MEM_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_o |-> $past(mem_re_i)) else $error("row data without request"); // R6
endmodule

// File: tb/sim_srf_core.sv
module sim_srf_core;
  localparam int LANES = 8, WORD_W = 32, ROWS = 64, SLOTS = 4;
  localparam int ROW_W = 6, PTR_W = 7, ID_W = 2, LEN_W = 10, NRP = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic                    cmd_valid;
  logic [1:0]              cmd_op;
  logic [ID_W-1:0]         cmd_id;
  logic [LEN_W-1:0]        cmd_len;
  logic                    cmd_ack, cmd_err;
  logic [PTR_W-1:0]        cmd_base;
  logic                    mem_we, mem_re;
  logic [ID_W-1:0]         mem_id;
  logic [ROW_W-1:0]        mem_row;
  logic [LANES*WORD_W-1:0] mem_wdata, mem_rdata;
  logic                    mem_rvalid;
  logic [LANES-1:0]        lane_we, lane_wstall;
  logic [LANES*ID_W-1:0]   lane_wid;
  logic [LANES*ROW_W-1:0]  lane_widx;
  logic [LANES*WORD_W-1:0] lane_wdata;
  logic [NRP-1:0]          lane_re, lane_rvalid, lane_rstall;
  logic [NRP*ID_W-1:0]     lane_rid;
  logic [NRP*ROW_W-1:0]    lane_ridx;
  logic [NRP*WORD_W-1:0]   lane_rdata;

  srf_core #(.LANES(LANES), .WORD_W(WORD_W), .ROWS(ROWS), .SLOTS(SLOTS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_id_i(cmd_id), .cmd_len_i(cmd_len),
    .cmd_ack_o(cmd_ack), .cmd_err_o(cmd_err), .cmd_base_o(cmd_base),
    .mem_we_i(mem_we), .mem_re_i(mem_re), .mem_id_i(mem_id), .mem_row_i(mem_row),
    .mem_wdata_i(mem_wdata), .mem_rdata_o(mem_rdata), .mem_rvalid_o(mem_rvalid),
    .lane_we_i(lane_we), .lane_wid_i(lane_wid), .lane_widx_i(lane_widx),
    .lane_wdata_i(lane_wdata), .lane_wstall_o(lane_wstall),
    .lane_re_i(lane_re), .lane_rid_i(lane_rid), .lane_ridx_i(lane_ridx),
    .lane_rdata_o(lane_rdata), .lane_rvalid_o(lane_rvalid), .lane_rstall_o(lane_rstall)
  );

  int total = 0;
  int bad   = 0;
  bit bvld  [SLOTS];
  int bbase [SLOTS];
  int brows [SLOTS];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int s, input int i);
    return {8'hA5, 4'(s), 20'(i)};
  endfunction

  task automatic idle();
    cmd_valid = 1'b0; cmd_op = '0; cmd_id = '0; cmd_len = '0;
    mem_we = 1'b0; mem_re = 1'b0; mem_id = '0; mem_row = '0; mem_wdata = '0;
    lane_we = '0; lane_wid = '0; lane_widx = '0; lane_wdata = '0;
    lane_re = '0; lane_rid = '0; lane_ridx = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int model_fit(input int need);
    for (int c = 0; c <= SLOTS; c++) begin
      int cb;
      bit ok;
      if (c == 0) cb = 0;
      else if (bvld[c-1]) cb = bbase[c-1] + brows[c-1];
      else continue;
      if (cb + need > ROWS) continue;
      ok = 1'b1;
      for (int k = 0; k < SLOTS; k++)
        if (bvld[k] && !((cb + need <= bbase[k]) || (cb >= bbase[k] + brows[k]))) ok = 1'b0;
      if (ok) return cb;
    end
    return -1;
  endfunction

  task automatic do_alloc(input int id, input int len, input string req);
    int need, fitb;
    bit experr;
    need   = (len + LANES - 1) / LANES;
    fitb   = model_fit(need);
    experr = (len == 0) || bvld[id] || (fitb < 0);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_id = ID_W'(id); cmd_len = LEN_W'(len);
    tick();
    chk(req, 32'(cmd_ack), 32'd1, "alloc ack");
    chk(req, 32'(cmd_err), 32'(experr), "alloc err");
    if (!experr) begin
      chk(req, 32'(cmd_base), 32'(fitb), "alloc base");
      bvld[id] = 1'b1; bbase[id] = fitb; brows[id] = need;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] op, input int id, input string req);
    bit experr;
    experr = !bvld[id];
    cmd_valid = 1'b1; cmd_op = op; cmd_id = ID_W'(id); cmd_len = '0;
    tick();
    chk(req, 32'(cmd_ack), 32'd1, "cmd ack");
    chk(req, 32'(cmd_err), 32'(experr), "cmd err");
    if (!experr && op == 2'b10) bvld[id] = 1'b0;
    cmd_valid = 1'b0;
  endtask

  task automatic set_rd(input int l, input int p, input int id, input int idx);
    int q;
    q = 2 * l + p;
    lane_re[q] = 1'b1;
    lane_rid[q*ID_W +: ID_W]    = ID_W'(id);
    lane_ridx[q*ROW_W +: ROW_W] = ROW_W'(idx);
  endtask

  task automatic set_wr(input int l, input int id, input int idx, input logic [31:0] d);
    lane_we[l] = 1'b1;
    lane_wid[l*ID_W +: ID_W]    = ID_W'(id);
    lane_widx[l*ROW_W +: ROW_W] = ROW_W'(idx);
    lane_wdata[l*WORD_W +: WORD_W] = d;
  endtask

  function automatic logic [31:0] rdat(input int q);
    return lane_rdata[q*WORD_W +: WORD_W];
  endfunction

  function automatic logic [31:0] mdat(input int l);
    return mem_rdata[l*WORD_W +: WORD_W];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    for (int k = 0; k < SLOTS; k++) begin bvld[k] = 1'b0; bbase[k] = 0; brows[k] = 0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", 32'(cmd_ack), 0, "ack in reset");
    chk("R10", 32'(cmd_err), 0, "err in reset");
    chk("R10", 32'(lane_rvalid), 0, "lane rvalid in reset");
    chk("R10", 32'(mem_rvalid), 0, "mem rvalid in reset");
    rst_ni = 1'b1;
    tick();

    // R2 / R3 / R4 placement
    do_alloc(0, 100, "R2");   // base 0, 13 rows
    do_alloc(1, 64,  "R2");   // base 13
    do_alloc(2, 400, "R3");   // no fit
    do_alloc(2, 344, "R2");   // base 21, fills bank
    do_alloc(3, 1,   "R3");   // bank full
    do_alloc(0, 5,   "R3");   // slot live
    do_alloc(3, 0,   "R3");   // zero length
    do_cmd(2'b10, 1, "R4");
    do_cmd(2'b10, 1, "R4");   // not live
    do_alloc(3, 16,  "R2");   // hole at 13

    // load stream 0 and 3 from memory side
    for (int r = 0; r < 13; r++) begin
      mem_we = 1'b1; mem_id = 2'd0; mem_row = ROW_W'(r);
      for (int l = 0; l < LANES; l++) mem_wdata[l*WORD_W +: WORD_W] = pat(0, r*LANES + l);
      tick();
    end
    for (int r = 0; r < 2; r++) begin
      mem_we = 1'b1; mem_id = 2'd3; mem_row = ROW_W'(r);
      for (int l = 0; l < LANES; l++) mem_wdata[l*WORD_W +: WORD_W] = pat(3, r*LANES + l);
      tick();
    end
    idle();

    // R5 unsealed read stalls
    set_rd(0, 0, 0, 0);
    #1 chk("R5", 32'(lane_rstall[0]), 1, "stall unsealed");
    tick();
    chk("R5", 32'(lane_rvalid[0]), 0, "no data unsealed");
    idle();
    do_cmd(2'b11, 0, "R5");
    do_cmd(2'b11, 3, "R5");

    // R1 / R6 full sweep, both ports of every lane
    for (int r = 0; r < 13; r++) begin
      for (int l = 0; l < LANES; l++) begin
        set_rd(l, 0, 0, r);
        set_rd(l, 1, 0, 12 - r);
      end
      #1 chk("R6", 32'(lane_rstall), 0, "no stall sealed");
      tick();
      chk("R6", 32'(lane_rvalid), 32'hFFFF, "all valid");
      for (int l = 0; l < LANES; l++) begin
        chk("R1", rdat(2*l),   pat(0, r*LANES + l),        "port0 element");
        chk("R1", rdat(2*l+1), pat(0, (12-r)*LANES + l),   "port1 element");
      end
      idle();
    end

    // R7 lane read/write collision
    set_wr(3, 0, 5, 32'h1234_5678);
    set_rd(3, 0, 0, 5);
    tick();
    chk("R7", rdat(6), pat(0, 43), "old data on collision");
    idle();
    set_rd(3, 0, 0, 5);
    tick();
    chk("R7", rdat(6), 32'h1234_5678, "new data after");
    idle();

    // R8 memory side blocks lanes
    mem_we = 1'b1; mem_id = 2'd2; mem_row = '0;
    for (int l = 0; l < LANES; l++) mem_wdata[l*WORD_W +: WORD_W] = pat(2, l);
    set_wr(1, 0, 2, 32'hDEAD_BEEF);
    set_rd(1, 1, 0, 2);
    #1 chk("R8", 32'(lane_wstall[1]), 1, "write stall");
    chk("R8", 32'(lane_rstall[3]), 1, "read stall");
    tick();
    chk("R8", 32'(lane_rvalid[3]), 0, "no lane data");
    idle();
    set_rd(1, 1, 0, 2);
    tick();
    chk("R8", rdat(3), pat(0, 17), "lane write blocked");
    idle();

    // R9 out-of-range and dead slot
    set_wr(0, 0, 13, 32'hBAD0_0000);
    set_rd(0, 0, 0, 13);
    set_rd(0, 1, 1, 0);
    #1 chk("R9", 32'(lane_rstall[1:0]), 0, "no stall on miss");
    tick();
    chk("R9", 32'(lane_rvalid[1:0]), 0, "no data on miss");
    idle();
    set_rd(0, 0, 3, 0);
    tick();
    chk("R9", rdat(0), pat(3, 0), "neighbour row intact");
    idle();

    // R1 lane writes into unsealed stream 2, read back on memory side
    for (int r = 1; r < 5; r++) begin
      for (int l = 0; l < LANES; l++) set_wr(l, 2, r, pat(2, r*LANES + l));
      #1 chk("R1", 32'(lane_wstall), 0, "lane write free");
      tick();
      idle();
    end
    for (int r = 0; r < 5; r++) begin
      mem_re = 1'b1; mem_id = 2'd2; mem_row = ROW_W'(r);
      tick();
      chk("R6", 32'(mem_rvalid), 1, "mem rvalid");
      for (int l = 0; l < LANES; l++) chk("R1", mdat(l), pat(2, r*LANES + l), "row word");
      idle();
    end

    // R7 memory side collision
    mem_we = 1'b1; mem_re = 1'b1; mem_id = 2'd2; mem_row = 6'd4;
    for (int l = 0; l < LANES; l++) mem_wdata[l*WORD_W +: WORD_W] = pat(7, l);
    tick();
    for (int l = 0; l < LANES; l++) chk("R7", mdat(l), pat(2, 32 + l), "mem old data");
    idle();
    mem_re = 1'b1; mem_id = 2'd2; mem_row = 6'd4;
    tick();
    for (int l = 0; l < LANES; l++) chk("R7", mdat(l), pat(7, l), "mem new data");
    idle();

    // R5 reallocation clears seal; R4 free keeps rows
    do_cmd(2'b10, 3, "R4");
    do_alloc(1, 8, "R2");     // base 13
    set_rd(0, 0, 1, 0);
    #1 chk("R5", 32'(lane_rstall[0]), 1, "new stream unsealed");
    tick();
    chk("R5", 32'(lane_rvalid[0]), 0, "no data before seal");
    idle();
    do_cmd(2'b11, 1, "R5");
    set_rd(0, 0, 1, 0);
    tick();
    chk("R4", rdat(0), pat(3, 0), "freed rows not erased");
    idle();

    // R2 / R3 / R4 sweep against the placement model
    for (int k = 0; k < SLOTS; k++) if (bvld[k]) do_cmd(2'b10, k, "R4");
    begin
      logic [31:0] seed;
      seed = 32'h1357_2468;
      for (int it = 0; it < 120; it++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        if (seed[20]) do_alloc(int'(seed[17:16]), int'(seed[30:22] % 9'd300), "R2");
        else          do_cmd(2'b10, int'(seed[17:16]), "R4");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule